// File: doc/BRIEF.md
# Spread-spectrum modulation profile generator

This block steers a clock synthesizer so that its output frequency sweeps slowly across a narrow band, lowering the peak of every harmonic. Each clock it produces a signed frequency-offset word that is added to the synthesizer's frequency control. It also produces a code that names the nominal multiplication setting for the chosen configuration, and a flag that tells the output stage when the clock may be driven.

A 3-bit select input picks the configuration. Each configuration fixes the sweep depth and the spread type. In center spread the offset swings evenly above and below the nominal frequency. In down spread it stays between the lower band edge and the nominal maximum. The sweep follows a symmetric triangle of 2N points per period, one point per clock. The default period is 1024 clocks. A rising edge on the resync input restarts the triangle at its first point, so several generators can be brought into lockstep. An active-low enable turns modulation off without stopping the sweep position. An active-low power-down input drops the output-enable flag and parks the profile. After power-down is released, the flag comes back after a fixed number of clocks.

The offset is two's complement. Its largest positive value (2047 at the default 12-bit width) stands for 2.5 % of the nominal frequency.

Top module: `ssmod_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `offset`, `out_en`, `bad_sel` and `mult_code` become 0.
- R2: `offset` is a register that reflects the phase and the inputs sampled at the previous edge. With phase p in 0..2N-1, let t = p for p < N and t = 2N-p otherwise. For center codes the offset is floor((2t-N)·A / N). A = 2047 for codes 000, 010 and 011, and A = 1228 for code 001. Over one period the offset therefore reaches exactly -A and +A.
- R3: For down codes 100 and 110 the offset is floor((t-N)·D / N) with D = 1637. It reaches -1637 and is never above 0.
- R4: The phase starts at 0 and advances by one each clock, wrapping after 2N-1 (default N = 512). Phase 0 gives the negative extreme, and the same value returns 2N clocks later.
- R5: `mult_code` is registered from the select input: 000, 001 and 010 give 2 (×2); 011 gives 1 (×1); 100 gives 4 (66.66 MHz setting); 110 gives 5 (100 MHz setting); 101 and 111 give 0.
- R6: Reserved codes 101 and 111 force `offset` to 0 and set `bad_sel` to 1. Every other code clears `bad_sel`.
- R7: When `spread_en_n` is sampled high, `offset` becomes 0 at the next edge while the phase keeps advancing.
- R8: `resync` passes through two synchronizer flops. A rising edge of the synchronized signal clears the phase at the next clock. If `resync` is raised just before edge E0, `offset` shows the phase-0 value after edge E3.
- R9: At the first edge where `pwrdn_n` is sampled low, `out_en` and `offset` become 0, and the phase is held at 0.
- R10: `out_en` returns to 1 at the RELOCK-th edge (default 4) at which `pwrdn_n` is sampled high, counted from power-down or from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 3 | Frequency / spread configuration select |
| spread_en_n | input | 1 | Modulation enable, active low |
| resync | input | 1 | Profile restart; the rising edge is used |
| pwrdn_n | input | 1 | Power-down, active low |
| offset | output | OFS_W | Signed frequency-offset word |
| mult_code | output | 3 | Nominal multiplication setting code |
| out_en | output | 1 | Clock output enable flag |
| bad_sel | output | 1 | Reserved select code in use |

## Verification
The offset is a pure function of the phase and the registered inputs. A phase counter that slips, wraps at the wrong point or misses a restart therefore shows as a wrong offset on the very next clock. A scaling or folding error shows as wrong peak values during a full sweep of each code. A power-down counter that is off by one moves the rising edge of `out_en` by a whole clock, and this is compared at the exact cycle. Random sequences of codes, enables, power-down and resync edges are compared every cycle against a model built from the requirements. Directed sweeps confirm the extremes and the down-spread ceiling.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    typedef enum logic [1:0] {
        SPR_NONE   = 2'd0,
        SPR_CENTER = 2'd1,
        SPR_DOWN   = 2'd2
    } spr_kind_e;

    typedef enum logic [2:0] {
        MUL_NONE   = 3'd0,
        MUL_X1     = 3'd1,
        MUL_X2     = 3'd2,
        MUL_SYN66  = 3'd4,
        MUL_SYN100 = 3'd5
    } mul_code_e;

    // depth is expressed in fifths of full scale (5/5 = 2.5 %)
    typedef struct packed {
        spr_kind_e kind;
        logic [2:0] fifths;
        mul_code_e mul;
    } sel_cfg_t;

    function automatic sel_cfg_t decode_sel(input logic [2:0] code);
        sel_cfg_t c;
        c = '{kind: SPR_NONE, fifths: 3'd0, mul: MUL_NONE};
        case (code)
            3'b000: c = '{kind: SPR_CENTER, fifths: 3'd5, mul: MUL_X2};
            3'b001: c = '{kind: SPR_CENTER, fifths: 3'd3, mul: MUL_X2};
            3'b010: c = '{kind: SPR_CENTER, fifths: 3'd5, mul: MUL_X2};
            3'b011: c = '{kind: SPR_CENTER, fifths: 3'd5, mul: MUL_X1};
            3'b100: c = '{kind: SPR_DOWN,   fifths: 3'd4, mul: MUL_SYN66};
            3'b110: c = '{kind: SPR_DOWN,   fifths: 3'd4, mul: MUL_SYN100};
            default: c = '{kind: SPR_NONE,  fifths: 3'd0, mul: MUL_NONE};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ssm_phase.sv
module ssm_phase #(
    parameter int LOG2N = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             resync_in,
    output logic [LOG2N:0]   phase
);
    localparam int PW = LOG2N + 1;

    logic sync_a, sync_b, sync_c;
    logic restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
            sync_c <= 1'b0;
        end else begin
            sync_a <= resync_in;
            sync_b <= sync_a;
            sync_c <= sync_b;
        end
    end

    assign restart = sync_b && !sync_c;

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            phase <= '0;
        end else begin
            phase <= phase + PW'(1);
        end
    end

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst) restart |=> (phase == '0)); // R8
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst) (run && !restart) |=> (phase == $past(phase) + PW'(1))); // R4
    AST_PARK_ZERO: assert property (@(posedge clk) disable iff (rst) !run |=> (phase == '0)); // R9

endmodule

// File: rtl/ssm_shape.sv
module ssm_shape
    import ssm_pkg::*;
#(
    parameter int OFS_W = 12,
    parameter int LOG2N = 9
) (
    input  logic [LOG2N:0]           phase,
    input  spr_kind_e                kind,
    input  logic [2:0]               fifths,
    output logic signed [OFS_W-1:0]  shaped
);
    localparam int PW  = LOG2N + 1;
    localparam int N   = 1 << LOG2N;
    localparam int FS  = (1 << (OFS_W - 1)) - 1;
    localparam int PRW = PW + OFS_W + 2;
    localparam logic signed [PRW-1:0] AMP5 = PRW'(FS);
    localparam logic signed [PRW-1:0] AMP4 = PRW'((FS * 4) / 5);
    localparam logic signed [PRW-1:0] AMP3 = PRW'((FS * 3) / 5);
    localparam logic signed [PRW-1:0] NS   = PRW'(N);

    logic [PW-1:0]          fold;
    logic signed [PRW-1:0]  t_s;
    logic signed [PRW-1:0]  amp;
    logic signed [PRW-1:0]  prod;
    logic signed [PRW-1:0]  scaled;

    always_comb begin
        // fold the phase into a triangle height 0..N..1
        fold = phase[LOG2N] ? (~phase + PW'(1)) : phase;
        t_s  = $signed(PRW'(fold));
        case (fifths)
            3'd3:    amp = AMP3;
            3'd4:    amp = AMP4;
            default: amp = AMP5;
        endcase
        case (kind)
            SPR_CENTER: prod = (t_s + t_s - NS) * amp;
            SPR_DOWN:   prod = (t_s - NS) * amp;
            default:    prod = '0;
        endcase
        scaled = prod >>> LOG2N;
        shaped = OFS_W'(scaled);
    end

endmodule

// File: rtl/ssm_relock.sv
module ssm_relock #(
    parameter int RELOCK = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pwrdn_n,
    output logic out_en
);
    localparam int CW = $clog2(RELOCK + 1);

    logic [CW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst || !pwrdn_n) begin
            wait_cnt <= '0;
            out_en   <= 1'b0;
        end else if (wait_cnt == CW'(RELOCK - 1)) begin
            out_en   <= 1'b1;
        end else begin
            wait_cnt <= wait_cnt + CW'(1);
        end
    end

    AST_PD_DROPS_EN: assert property (@(posedge clk) disable iff (rst) !pwrdn_n |=> !out_en); // R9
    AST_NO_EARLY_EN: assert property (@(posedge clk) disable iff (rst) (!out_en && wait_cnt != CW'(RELOCK - 1)) |=> !out_en); // R10
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (wait_cnt <= CW'(RELOCK - 1))); // R10

endmodule

// File: rtl/ssmod_gen.sv
module ssmod_gen
    import ssm_pkg::*;
#(
    parameter int OFS_W  = 12,
    parameter int LOG2N  = 9,
    parameter int RELOCK = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [2:0]               sel,
    input  logic                     spread_en_n,
    input  logic                     resync,
    input  logic                     pwrdn_n,
    output logic signed [OFS_W-1:0]  offset,
    output logic [2:0]               mult_code,
    output logic                     out_en,
    output logic                     bad_sel
);
    localparam int PW = LOG2N + 1;

    sel_cfg_t                 cfg;
    logic [PW-1:0]            phase;
    logic signed [OFS_W-1:0]  shaped;
    logic                     hold_zero;

    assign cfg = decode_sel(sel);

    ssm_phase #(.LOG2N(LOG2N)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .run       (pwrdn_n),
        .resync_in (resync),
        .phase     (phase)
    );

    ssm_shape #(.OFS_W(OFS_W), .LOG2N(LOG2N)) u_shape (
        .phase  (phase),
        .kind   (cfg.kind),
        .fifths (cfg.fifths),
        .shaped (shaped)
    );

    ssm_relock #(.RELOCK(RELOCK)) u_relock (
        .clk     (clk),
        .rst     (rst),
        .pwrdn_n (pwrdn_n),
        .out_en  (out_en)
    );

    assign hold_zero = !pwrdn_n || spread_en_n || (cfg.kind == SPR_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            offset    <= '0;
            mult_code <= '0;
            bad_sel   <= 1'b0;
        end else begin
            offset    <= hold_zero ? '0 : shaped;
            mult_code <= cfg.mul;
            bad_sel   <= (cfg.kind == SPR_NONE);
        end
    end

    AST_SPREAD_OFF_ZERO: assert property (@(posedge clk) disable iff (rst) spread_en_n |=> (offset == '0)); // R7
    AST_DOWN_CEILING: assert property (@(posedge clk) disable iff (rst) (sel[2] && !sel[0]) |=> (offset[OFS_W-1] || offset == '0)); // R3
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst) (sel[2] && sel[0]) |=> (offset == '0 && bad_sel)); // R6
    AST_PD_OFFSET_ZERO: assert property (@(posedge clk) disable iff (rst) !pwrdn_n |=> (offset == '0)); // R9

endmodule

// File: tb/ssmod_gen_tb.sv
module ssmod_gen_tb;
    localparam int OFS_W  = 12;
    localparam int LOG2N  = 9;
    localparam int N      = 1 << LOG2N;
    localparam int RELOCK = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] sel = 3'b000;
    logic spread_en_n = 1'b0;
    logic resync = 1'b0;
    logic pwrdn_n = 1'b1;
    logic signed [OFS_W-1:0] offset;
    logic [2:0] mult_code;
    logic out_en;
    logic bad_sel;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit trk = 1'b0;
    int mn, mx;

    always #10 clk = ~clk;

    ssmod_gen #(.OFS_W(OFS_W), .LOG2N(LOG2N), .RELOCK(RELOCK)) u_dut (
        .clk(clk), .rst(rst), .sel(sel), .spread_en_n(spread_en_n),
        .resync(resync), .pwrdn_n(pwrdn_n), .offset(offset),
        .mult_code(mult_code), .out_en(out_en), .bad_sel(bad_sel)
    );

    function automatic int exp_off(int ph, logic [2:0] s);
        int t;
        t = (ph < N) ? ph : 2 * N - ph;
        case (s)
            3'd0, 3'd2, 3'd3: return ((2 * t - N) * 2047) >>> LOG2N;
            3'd1:             return ((2 * t - N) * 1228) >>> LOG2N;
            3'd4, 3'd6:       return ((t - N) * 1637) >>> LOG2N;
            default:          return 0;
        endcase
    endfunction

    function automatic int exp_mult(logic [2:0] s);
        case (s)
            3'd0, 3'd1, 3'd2: return 2;
            3'd3:             return 1;
            3'd4:             return 4;
            3'd6:             return 5;
            default:          return 0;
        endcase
    endfunction

    function automatic string off_tag(logic [2:0] s, logic dis, logic pdn);
        if (!pdn) return "R9";
        if (s == 3'd5 || s == 3'd7) return "R6";
        if (dis) return "R7";
        if (s == 3'd4 || s == 3'd6) return "R3";
        return "R2";
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // reference model built from the requirement text
    logic m_a, m_b, m_c;
    int m_ph, m_off, m_mult, m_cnt;
    logic m_en, m_bad;
    string m_tag;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_a <= 0; m_b <= 0; m_c <= 0;
            m_ph <= 0; m_off <= 0; m_mult <= 0; m_bad <= 0;
            m_en <= 0; m_cnt <= 0; m_tag <= "R1";
        end else begin
            m_a <= resync; m_b <= m_a; m_c <= m_b;
            if (!pwrdn_n || (m_b && !m_c)) m_ph <= 0;
            else m_ph <= (m_ph + 1) % (2 * N);
            m_off <= (!pwrdn_n || spread_en_n) ? 0 : exp_off(m_ph, sel);
            m_mult <= exp_mult(sel);
            m_bad <= (sel == 3'd5 || sel == 3'd7);
            m_tag <= off_tag(sel, spread_en_n, pwrdn_n);
            if (!pwrdn_n) begin
                m_cnt <= 0; m_en <= 0;
            end else if (m_cnt == RELOCK - 1) begin
                m_en <= 1;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (mon_on && !rst) begin
            check(m_tag, int'(offset), m_off, "offset");
            check("R10", int'(out_en), int'(m_en), "out_en");
            check("R5", int'(mult_code), m_mult, "mult_code");
            check("R6", int'(bad_sel), int'(m_bad), "bad_sel");
            if (trk) begin
                if (int'(offset) < mn) mn = int'(offset);
                if (int'(offset) > mx) mx = int'(offset);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc == 190000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    task automatic sweep(logic [2:0] s, int exp_mx, int exp_mn, string tag);
        sel = s; spread_en_n = 1'b0; pwrdn_n = 1'b1;
        tick(2);
        mn = 32'h7fffffff; mx = -32'h7fffffff;
        trk = 1'b1;
        tick(2 * N);
        trk = 1'b0;
        check(tag, mx, exp_mx, "sweep maximum");
        check(tag, mn, exp_mn, "sweep minimum");
    endtask

    initial begin
        void'($urandom(32'h5eed1234));
        // R1: reset state
        tick(3);
        check("R1", int'(offset), 0, "offset in reset");
        check("R1", int'(out_en), 0, "out_en in reset");
        check("R1", int'(bad_sel), 0, "bad_sel in reset");
        check("R1", int'(mult_code), 0, "mult_code in reset");
        rst = 1'b0;
        mon_on = 1'b1;
        tick(8);

        // R8 and R4: restart lands on phase 0, period is 2N
        sel = 3'd0;
        tick(3);
        resync = 1'b1;
        tick(4);
        check("R8", int'(offset), -2047, "offset after restart");
        tick(N);
        check("R4", int'(offset), 2047, "offset half period after restart");
        tick(N);
        check("R4", int'(offset), -2047, "offset one period after restart");
        resync = 1'b0;
        tick(5);

        // R9 and R10: power-down drops the enable, relock timing
        pwrdn_n = 1'b0;
        tick(1);
        check("R9", int'(out_en), 0, "out_en after power-down");
        check("R9", int'(offset), 0, "offset after power-down");
        tick(6);
        pwrdn_n = 1'b1;
        tick(RELOCK - 1);
        check("R10", int'(out_en), 0, "out_en one edge before relock");
        tick(1);
        check("R10", int'(out_en), 1, "out_en at relock edge");

        // R7: modulation off holds offset at zero
        spread_en_n = 1'b1;
        tick(2);
        check("R7", int'(offset), 0, "offset with spread disabled");
        spread_en_n = 1'b0;

        // full sweeps: extremes and the down-spread ceiling
        sweep(3'd0, 2047, -2047, "R2");
        sweep(3'd1, 1228, -1228, "R2");
        sweep(3'd3, 2047, -2047, "R2");
        sweep(3'd4, 0, -1637, "R3");
        sweep(3'd6, 0, -1637, "R3");
        sweep(3'd5, 0, 0, "R6");

        // constrained random mixture
        for (int seg = 0; seg < 60; seg++) begin
            int len;
            sel = 3'($urandom_range(0, 7));
            spread_en_n = ($urandom_range(0, 5) == 0);
            pwrdn_n = ($urandom_range(0, 7) != 0);
            len = $urandom_range(5, 400);
            for (int c = 0; c < len; c++) begin
                if ($urandom_range(0, 99) == 0) resync = ~resync;
                tick(1);
            end
        end
        pwrdn_n = 1'b1;
        tick(RELOCK + 2);
        check("R10", int'(out_en), 1, "out_en at end of run");

        mon_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule